// File: doc/BRIEF.md
# Nibble-Polarity Event Sense Unit

This unit watches 32 already-filtered digital inputs, organised as four 8-bit ports, and records transitions on them as per-channel events. The edge direction that counts as an event is chosen for each group of four neighbouring channels. Whether a channel may record events at all is chosen one channel at a time. A recorded event is held in a sticky status bit until software clears it by writing a 1 to that bit. While a channel's bit is set, further transitions on that channel change nothing.

The unit also reduces the status to an 8-bit summary. That summary has one bit per port and a global flag. It drives an active-low interrupt request whenever some status bit is set and the interrupt-enable bit is 1. Detection runs only while the enhanced-mode qualifier is high. A small mode sequencer handles this. Its states are `SENSE_OFF` (detection inhibited, edge history frozen), `SENSE_PRIME` (one cycle that reloads the edge history and still detects nothing) and `SENSE_ARMED` (detection active). Its transitions are:
- *enter*: `SENSE_OFF`→`SENSE_PRIME` when the qualifier is high.
- *arm*: `SENSE_PRIME`→`SENSE_ARMED` when the qualifier is still high.
- *drop*: `SENSE_PRIME` or `SENSE_ARMED`→`SENSE_OFF` when the qualifier falls.
- *restart*: any state→`SENSE_OFF` on software reset.

Top module: `nibble_event_sense`

## Requirements
- R1: After `rst_n` low or a cycle with `soft_rst_i` high, all status bits read 0, every channel is disabled, and every nibble polarity is positive (rising edge).
- R2: Bit k of `pol_wdata_i`, written with `pol_we_i`, selects the polarity of channels 4k..4k+3. A 0 selects low-to-high and a 1 selects high-to-low. An edge of the opposite direction sets nothing.
- R3: Bit i of `en_wdata_i`, written with `en_we_i`, enables channel i. A disabled channel never sets its status bit.
- R4: A set status bit stays set until it is cleared or reset. Further edges on that channel have no effect.
- R5: In a cycle with `clr_we_i` high, status bits whose `clr_wdata_i` bit is 1 are cleared, and bits written 0 are untouched. A qualifying edge in the same cycle as its clear leaves the bit set.
- R6: `summary_o` bit p (p = 0..3) is the OR of the status bits of port p (channels 8p..8p+7). Bit 7 is the OR of all status bits. Bits 4 to 6 read 0.
- R7: `irq_n_o` is 0 exactly when `irq_en_i` is 1 and at least one status bit is set. Otherwise it is 1.
- R8: No status bit is set while `enh_mode_i` is low. After it rises, the first clock edge moves to `SENSE_PRIME` and the second reloads the edge history. Detection starts at the third edge, so input changes made while the mode was off produce no event.
- R9: When armed, an enabled qualifying input change that is present before a clock edge is visible in `evt_status_o` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous software reset of the event logic |
| enh_mode_i | input | 1 | Enhanced-mode qualifier; detection only while high |
| din_i | input | 32 | Filtered input levels, channel i on bit i |
| pol_we_i | input | 1 | Write strobe for nibble polarity |
| pol_wdata_i | input | 8 | Polarity per nibble, 1 = falling edge |
| en_we_i | input | 1 | Write strobe for channel enables |
| en_wdata_i | input | 32 | Enable per channel |
| clr_we_i | input | 1 | Write strobe for status clear |
| clr_wdata_i | input | 32 | Write-1-to-clear mask for status |
| irq_en_i | input | 1 | Interrupt enable |
| evt_status_o | output | 32 | Sticky per-channel event status |
| summary_o | output | 8 | Per-port summary bits 0..3, global flag bit 7 |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the unit with its default parameters: four ports of eight channels and 4-channel polarity groups. Each port therefore holds two independently polarised nibbles, so one port can carry rising and falling detectors side by side. The single 8-bit summary leaves room for the unused bits 4 to 6. With 32 channels, the directed sequences reach a port whose channels are all disabled while its neighbours latch events. They also cover clears that coincide with new edges and a mode drop followed by re-priming.

// File: rtl/esu_pkg.sv
package esu_pkg;
    typedef enum logic [1:0] {
        SENSE_OFF   = 2'd0,
        SENSE_PRIME = 2'd1,
        SENSE_ARMED = 2'd2
    } sense_state_e;

    localparam int SUM_W      = 8;
    localparam int GLOBAL_BIT = 7;
endpackage

// File: rtl/esu_mode_fsm.sv
module esu_mode_fsm
    import esu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst_i,
    input  logic enh_mode_i,
    output logic hist_load_o,
    output logic detect_en_o
);
    sense_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (soft_rst_i) begin
            state_d = SENSE_OFF;                  // restart
        end else begin
            unique case (state_q)
                SENSE_OFF:   if (enh_mode_i) state_d = SENSE_PRIME;  // enter
                SENSE_PRIME: state_d = enh_mode_i ? SENSE_ARMED : SENSE_OFF; // arm / drop
                SENSE_ARMED: if (!enh_mode_i) state_d = SENSE_OFF;   // drop
                default:     state_d = SENSE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SENSE_OFF;
        else        state_q <= state_d;
    end

    // Outputs: history reloads in PRIME and ARMED, detection only when armed (R8)
    always_comb begin
        hist_load_o = 1'b0;
        detect_en_o = 1'b0;
        unique case (state_q)
            SENSE_OFF:   ;
            SENSE_PRIME: hist_load_o = 1'b1;
            SENSE_ARMED: begin
                hist_load_o = 1'b1;
                detect_en_o = enh_mode_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/esu_config_regs.sv
module esu_config_regs #(
    parameter int NCH   = 32,
    parameter int NIB_W = 4,
    localparam int NNIB = NCH / NIB_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst_i,
    input  logic            pol_we_i,
    input  logic [NNIB-1:0] pol_wdata_i,
    input  logic            en_we_i,
    input  logic [NCH-1:0]  en_wdata_i,
    output logic [NCH-1:0]  chan_neg_o,
    output logic [NCH-1:0]  chan_en_o
);
    logic [NNIB-1:0] pol_q;
    logic [NCH-1:0]  en_q;

    // R1: reset leaves all channels disabled and positive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= '0;
            en_q  <= '0;
        end else if (soft_rst_i) begin
            pol_q <= '0;
            en_q  <= '0;
        end else begin
            if (pol_we_i) pol_q <= pol_wdata_i;
            if (en_we_i)  en_q  <= en_wdata_i;
        end
    end

    // R2: one polarity bit fans out to its group of channels
    for (genvar n = 0; n < NNIB; n++) begin : g_nib
        assign chan_neg_o[n*NIB_W +: NIB_W] = {NIB_W{pol_q[n]}};
    end

    assign chan_en_o = en_q;
endmodule

// File: rtl/esu_edge_detect.sv
module esu_edge_detect #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din_i,
    input  logic           hist_load_i,
    input  logic           detect_en_i,
    input  logic [NCH-1:0] chan_neg_i,
    input  logic [NCH-1:0] chan_en_i,
    output logic [NCH-1:0] hit_o
);
    logic [NCH-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hist_q <= '0;
        else if (hist_load_i) hist_q <= din_i;
    end

    logic [NCH-1:0] rise, fall;
    assign rise = din_i & ~hist_q;
    assign fall = ~din_i & hist_q;

    // R9: hit is combinational, so status latches on the sampling edge
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign hit_o[i] = detect_en_i & chan_en_i[i] & (chan_neg_i[i] ? fall[i] : rise[i]);
    end
endmodule

// File: rtl/esu_status_bank.sv
module esu_status_bank
    import esu_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    localparam int NCH      = NUM_PORTS * PORT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic [NCH-1:0]   hit_i,
    input  logic             clr_we_i,
    input  logic [NCH-1:0]   clr_wdata_i,
    input  logic             irq_en_i,
    output logic [NCH-1:0]   status_o,
    output logic [SUM_W-1:0] summary_o,
    output logic             irq_n_o
);
    logic [NCH-1:0] status_q;
    logic [NCH-1:0] clr_mask;

    assign clr_mask = clr_we_i ? clr_wdata_i : '0;

    // R4 sticky, R5 clear with event priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          status_q <= '0;
        else if (soft_rst_i) status_q <= '0;
        else                 status_q <= (status_q & ~clr_mask) | hit_i;
    end

    assign status_o = status_q;

    // R6: one summary bit per port, global flag on top
    logic [SUM_W-1:0] sum_w;
    always_comb begin
        sum_w = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            sum_w[p] = |status_q[p*PORT_W +: PORT_W];
        end
        sum_w[GLOBAL_BIT] = |status_q;
    end
    assign summary_o = sum_w;

    // R7: active-low request
    assign irq_n_o = ~(irq_en_i & (|status_q));
endmodule

// File: rtl/nibble_event_sense.sv
module nibble_event_sense
    import esu_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int NIB_W     = 4,
    localparam int NCH      = NUM_PORTS * PORT_W,
    localparam int NNIB     = NCH / NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             enh_mode_i,
    input  logic [NCH-1:0]   din_i,
    input  logic             pol_we_i,
    input  logic [NNIB-1:0]  pol_wdata_i,
    input  logic             en_we_i,
    input  logic [NCH-1:0]   en_wdata_i,
    input  logic             clr_we_i,
    input  logic [NCH-1:0]   clr_wdata_i,
    input  logic             irq_en_i,
    output logic [NCH-1:0]   evt_status_o,
    output logic [SUM_W-1:0] summary_o,
    output logic             irq_n_o
);
    logic           hist_load, detect_en;
    logic [NCH-1:0] chan_neg, chan_en, hit;

    esu_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst_i),
        .enh_mode_i  (enh_mode_i),
        .hist_load_o (hist_load),
        .detect_en_o (detect_en)
    );

    esu_config_regs #(.NCH(NCH), .NIB_W(NIB_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst_i),
        .pol_we_i    (pol_we_i),
        .pol_wdata_i (pol_wdata_i),
        .en_we_i     (en_we_i),
        .en_wdata_i  (en_wdata_i),
        .chan_neg_o  (chan_neg),
        .chan_en_o   (chan_en)
    );

    esu_edge_detect #(.NCH(NCH)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .din_i       (din_i),
        .hist_load_i (hist_load),
        .detect_en_i (detect_en),
        .chan_neg_i  (chan_neg),
        .chan_en_i   (chan_en),
        .hit_o       (hit)
    );

    esu_status_bank #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_i  (soft_rst_i),
        .hit_i       (hit),
        .clr_we_i    (clr_we_i),
        .clr_wdata_i (clr_wdata_i),
        .irq_en_i    (irq_en_i),
        .status_o    (evt_status_o),
        .summary_o   (summary_o),
        .irq_n_o     (irq_n_o)
    );
endmodule

// File: rtl/esu_checker.sv
module esu_checker #(
    parameter int NCH = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           soft_rst_i,
    input logic           enh_mode_i,
    input logic           clr_we_i,
    input logic           irq_en_i,
    input logic [NCH-1:0] evt_status_o,
    input logic [7:0]     summary_o,
    input logic           irq_n_o
);
    a_r1_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (evt_status_o == '0));

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_i && !clr_we_i) |=> ((evt_status_o & $past(evt_status_o)) == $past(evt_status_o)));

    a_r6_global_flag: assert property (@(posedge clk) disable iff (!rst_n)
        summary_o[7] == (|evt_status_o));

    a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        summary_o[6:4] == 3'b000);

    a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == !(irq_en_i && (|evt_status_o)));

    a_r8_off_no_new: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_mode_i |=> ((evt_status_o & ~$past(evt_status_o)) == '0));
endmodule

bind nibble_event_sense esu_checker #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_i   (soft_rst_i),
    .enh_mode_i   (enh_mode_i),
    .clr_we_i     (clr_we_i),
    .irq_en_i     (irq_en_i),
    .evt_status_o (evt_status_o),
    .summary_o    (summary_o),
    .irq_n_o      (irq_n_o)
);

// File: tb/nibble_event_sense_tb.sv
`timescale 1ns/1ps
module nibble_event_sense_tb_top;
    localparam int NCH  = 32;
    localparam int NNIB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, enh = 1'b0, pol_we = 1'b0, en_we = 1'b0, clr_we = 1'b0, irq_en = 1'b0;
    logic [NCH-1:0]  din = '0, en_wd = '0, clr_wd = '0;
    logic [NNIB-1:0] pol_wd = '0;
    logic [NCH-1:0]  status;
    logic [7:0]      summary;
    logic            irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nibble_event_sense dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .enh_mode_i(enh),
        .din_i(din), .pol_we_i(pol_we), .pol_wdata_i(pol_wd),
        .en_we_i(en_we), .en_wdata_i(en_wd), .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
        .irq_en_i(irq_en), .evt_status_o(status), .summary_o(summary), .irq_n_o(irq_n)
    );

    // Behavioural reference model
    bit m_stat[NCH];
    bit m_en[NCH];
    bit m_pol[NNIB];
    bit m_prev[NCH];
    int m_phase = 0;   // 0 off, 1 priming, 2 armed

    function automatic logic [NCH-1:0] m_status_vec();
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = m_stat[i];
        return v;
    endfunction

    function automatic logic [7:0] m_summary();
        logic [7:0] s = '0;
        for (int i = 0; i < NCH; i++) if (m_stat[i]) begin
            s[i/8] = 1'b1;
            s[7] = 1'b1;
        end
        return s;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_stat[i] = 0; m_en[i] = 0; m_prev[i] = 0;
            end
            for (int k = 0; k < NNIB; k++) m_pol[k] = 0;
            m_phase = 0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                bit edge_ok;
                edge_ok = m_pol[i/4] ? (m_prev[i] && !din[i]) : (!m_prev[i] && din[i]);
                if (clr_we && clr_wd[i]) m_stat[i] = 0;
                if (m_phase == 2 && enh && m_en[i] && edge_ok) m_stat[i] = 1;
            end
            if (m_phase != 0)
                for (int i = 0; i < NCH; i++) m_prev[i] = din[i];
            if (soft_rst) begin
                for (int i = 0; i < NCH; i++) begin m_stat[i] = 0; m_en[i] = 0; end
                for (int k = 0; k < NNIB; k++) m_pol[k] = 0;
                m_phase = 0;
            end else begin
                if (en_we)  for (int i = 0; i < NCH; i++) m_en[i] = en_wd[i];
                if (pol_we) for (int k = 0; k < NNIB; k++) m_pol[k] = pol_wd[k];
                m_phase = !enh ? 0 : (m_phase == 0 ? 1 : 2);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(status === m_status_vec(), "R4 status vs model", status, m_status_vec());
            check(summary === m_summary(), "R6 summary vs model", {24'h0, summary}, {24'h0, m_summary()});
            check(irq_n === !(irq_en && (m_status_vec() != '0)), "R7 irq vs model",
                  {31'h0, irq_n}, {31'h0, !(irq_en && (m_status_vec() != '0))});
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #3;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1: reset state
        check(status == '0, "R1 reset status", status, '0);
        check(summary == 8'h00, "R1 reset summary", {24'h0, summary}, 0);
        check(irq_n == 1'b1, "R1 reset irq", {31'h0, irq_n}, 1);

        // R8: arm
        enh = 1'b1;
        step(3);
        en_we = 1'b1; en_wd = '1; step(); en_we = 1'b0;

        // R9: one-edge latency
        din[0] = 1'b1; step();
        check(status == 32'h1, "R9 rising latched", status, 32'h1);
        check(summary == 8'h81, "R6 port0 and global", {24'h0, summary}, 32'h81);
        check(irq_n == 1'b1, "R7 irq disabled", {31'h0, irq_n}, 1);
        irq_en = 1'b1; step();
        check(irq_n == 1'b0, "R7 irq asserted", {31'h0, irq_n}, 0);

        // R2: nibble 1 set to falling
        pol_we = 1'b1; pol_wd = 8'h02; step(); pol_we = 1'b0;
        din[7:4] = 4'hF; step();
        check(status == 32'h1, "R2 rising ignored on falling nibble", status, 32'h1);
        din[7:4] = 4'h0; step();
        check(status == 32'hF1, "R2 falling latched", status, 32'hF1);

        // R4: sticky
        din[0] = 1'b0; step(); din[0] = 1'b1; step();
        check(status == 32'hF1, "R4 no re-signal", status, 32'hF1);

        // R5: clear with coincident event on bit 8
        clr_we = 1'b1; clr_wd = 32'h1F1; din[8] = 1'b1; step();
        check(status == 32'h100, "R5 clear, event wins", status, 32'h100);
        clr_wd = 32'h1; step(); clr_we = 1'b0;
        check(status == 32'h100, "R5 zero mask bits untouched", status, 32'h100);

        // R3: disable port 2
        en_we = 1'b1; en_wd = 32'hFF00_FFFF; step(); en_we = 1'b0;
        din[23:16] = 8'hFF; step();
        check(status == 32'h100, "R3 disabled channels silent", status, 32'h100);
        check(summary == 8'h82, "R6 port1 only", {24'h0, summary}, 32'h82);
        din[24] = 1'b1; step();
        check(status == 32'h0100_0100, "R3 enabled port3", status, 32'h0100_0100);
        check(summary == 8'h8A, "R6 ports1 and 3", {24'h0, summary}, 32'h8A);

        // R8: mode off, then re-prime
        enh = 1'b0; step();
        din[9] = 1'b1; step(2);
        check(status == 32'h0100_0100, "R8 no events when off", status, 32'h0100_0100);
        enh = 1'b1; step(3);
        check(status == 32'h0100_0100, "R8 no stale event after prime", status, 32'h0100_0100);
        din[10] = 1'b1; step();
        check(status == 32'h0100_0500, "R8 detection resumes", status, 32'h0100_0500);

        irq_en = 1'b0; step();
        check(irq_n == 1'b1, "R7 irq released", {31'h0, irq_n}, 1);

        // R1: software reset
        soft_rst = 1'b1; step(); soft_rst = 1'b0;
        check(status == '0, "R1 soft reset status", status, '0);
        check(summary == 8'h00, "R1 soft reset summary", {24'h0, summary}, 0);
        step(3);
        din[11] = 1'b1; step();
        check(status == '0, "R1 enables cleared", status, '0);
        en_we = 1'b1; en_wd = '1; step(); en_we = 1'b0;
        din[4] = 1'b1; step();
        check(status == 32'h10, "R1 polarity back to positive", status, 32'h10);
        step(2);
        finish_run();
    end
endmodule